// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `WORDS` rows, each `WIDTH` bits wide, that is searched by content instead of by address. A search presents an argument word together with a key word. Every stored row is compared against the argument at the same time. Only the bit positions where the key holds a 1 take part in the comparison. The outcome is one match bit per row, captured in a match register.

Rows are filled through a write port that names a row and carries the data and a live flag. Results are read one at a time. The lowest-numbered row whose match bit is set is presented together with its stored word, and the number of set match bits is given beside it. A pop strobe retires the presented row from the match register, so the next matching row comes forward. Searching, writing and popping each take effect at a single clock edge.

Top module: `cam_search_unit`

## Requirements
- R1: While reset is asserted, and until the first search afterwards, every row is invalid, the match register is empty, `hit_any` is 0, `hit_count` is 0, `hit_row` is 0 and `hit_data` is 0.
- R2: A write (`wr_en`=1) stores `wr_data` into row `wr_row` at the next clock edge and sets that row's valid flag to `wr_live`. No other row changes.
- R3: Bit j of a row agrees with the argument when both bits are 1 or both are 0. A row matches only if it agrees at every position where `key_in` is 1. For example, with argument 9'b101111100 and key 9'b111000000, the row 9'b101000011 matches and the row 9'b100111100 does not.
- R4: A position where `key_in` is 0 never prevents a match, whatever the stored and argument bits hold there.
- R5: A search with `key_in` all zeros sets the match bit of exactly the rows that are valid.
- R6: A row whose valid flag is 0 never gets its match bit set by a search.
- R7: The match register takes the search result at the clock edge where `search_en`=1 is sampled. The outputs show it from then on. Without a search or a pop, the match register holds its value.
- R8: When `wr_en` and `search_en` are both 1 in the same cycle, the write is performed and the search is ignored. The match register keeps its previous contents, apart from any pop in that cycle.
- R9: `hit_row` gives the lowest row index whose match bit is 1, and `hit_data` gives the word currently stored in that row. When no match bit is set, both are 0.
- R10: `hit_count` equals the number of set match bits, and `hit_any` is 1 exactly when that number is nonzero.
- R11: A pop (`pop`=1) with no accepted search in the same cycle clears the match bit of the row shown on `hit_row` at the next edge. A search accepted in the same cycle overrides the pop. A pop with no match bit set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_row | input | ROW_W | Row written |
| wr_data | input | WIDTH | Word written |
| wr_live | input | 1 | Valid flag given to the written row |
| search_en | input | 1 | Search strobe |
| arg_in | input | WIDTH | Argument word of a search |
| key_in | input | WIDTH | Per-bit compare enable of a search (1 = compare) |
| pop | input | 1 | Retire the presented match |
| hit_any | output | 1 | At least one match bit set |
| hit_count | output | CNT_W | Number of set match bits |
| hit_row | output | ROW_W | Lowest matching row |
| hit_data | output | WIDTH | Stored word of the lowest matching row |

## Verification
Every strobe (write, search or pop) acts at the clock edge that samples it. The outputs are decoded from registered state only, so each result is due one edge after its stimulus. The driver drives inputs on the falling edge and pushes an item stamped with the cycle on which it becomes due. The monitor pops and compares items only on the falling edge after the stamped rising edge. Expected values come from a bench-side model of rows, valid flags and match bits that is built from the requirements.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // Operation accepted in a cycle; a write outranks a search.
  typedef enum logic [1:0] {
    CAM_IDLE   = 2'd0,
    CAM_WRITE  = 2'd1,
    CAM_SEARCH = 2'd2
  } cam_op_e;
endpackage

// File: rtl/cam_storage.sv
module cam_storage #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  localparam int ROW_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_live,
  output logic [WIDTH-1:0] rows_o [WORDS],
  output logic [WORDS-1:0] valid_o
);
  logic [WORDS-1:0] valid_d;
  logic [WORDS-1:0] row_sel;

  for (genvar g = 0; g < WORDS; g++) begin : g_row
    assign row_sel[g] = wr_en && (wr_row == ROW_W'(g));

    // Data cells carry no reset; the valid flag guards them.
    always_ff @(posedge clk) begin
      if (row_sel[g]) rows_o[g] <= wr_data;
    end
  end

  always_comb begin
    valid_d = valid_o;
    for (int i = 0; i < WORDS; i++) begin
      if (row_sel[i]) valid_d[i] = wr_live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= '0;
    else        valid_o <= valid_d;
  end

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rows_o[$past(wr_row)] == $past(wr_data)) &&
              (valid_o[$past(wr_row)] == $past(wr_live)));
endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] rows_i [WORDS],
  input  logic [WORDS-1:0] valid_i,
  input  logic [WIDTH-1:0] arg_i,
  input  logic [WIDTH-1:0] key_i,
  output logic [WORDS-1:0] hit_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_cmp
    logic [WIDTH-1:0] agree;
    // Position passes when the bits are equal or the key leaves it out.
    assign agree    = ~(rows_i[g] ^ arg_i) | ~key_i;
    assign hit_o[g] = valid_i[g] & (&agree);
  end
endmodule

// File: rtl/cam_pick.sv
module cam_pick #(
  parameter int WORDS = 8,
  localparam int ROW_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDS-1:0] match_i,
  output logic             any_o,
  output logic [CNT_W-1:0] count_o,
  output logic [ROW_W-1:0] row_o,
  output logic [WORDS-1:0] grant_o
);
  always_comb begin
    row_o   = '0;
    grant_o = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        row_o   = ROW_W'(i);
        grant_o = WORDS'(1) << i;
      end
    end
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < WORDS; i++) count_o = count_o + CNT_W'(match_i[i]);
  end

  assign any_o = |match_i;

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (any_o == (grant_o != '0)));

  // R10
  any_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o == (count_o != '0));
endmodule

// File: rtl/cam_search_unit.sv
module cam_search_unit #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  localparam int ROW_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_live,
  input  logic             search_en,
  input  logic [WIDTH-1:0] arg_in,
  input  logic [WIDTH-1:0] key_in,
  input  logic             pop,
  output logic             hit_any,
  output logic [CNT_W-1:0] hit_count,
  output logic [ROW_W-1:0] hit_row,
  output logic [WIDTH-1:0] hit_data
);
  import cam_pkg::*;

  // Reset: asserted at once, released through two flops.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [WIDTH-1:0] rows [WORDS];
  logic [WORDS-1:0] valid;
  logic [WORDS-1:0] hit_vec;
  logic [WORDS-1:0] grant;
  logic [WORDS-1:0] match_q, match_d;
  cam_op_e          op;

  cam_storage #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_data (wr_data),
    .wr_live (wr_live),
    .rows_o  (rows),
    .valid_o (valid)
  );

  cam_compare #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cmp (
    .rows_i  (rows),
    .valid_i (valid),
    .arg_i   (arg_in),
    .key_i   (key_in),
    .hit_o   (hit_vec)
  );

  cam_pick #(.WORDS(WORDS)) u_pick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .match_i (match_q),
    .any_o   (hit_any),
    .count_o (hit_count),
    .row_o   (hit_row),
    .grant_o (grant)
  );

  always_comb begin
    if (wr_en)          op = CAM_WRITE;
    else if (search_en) op = CAM_SEARCH;
    else                op = CAM_IDLE;
  end

  always_comb begin
    match_d = match_q;
    if (op == CAM_SEARCH) match_d = hit_vec;
    else if (pop)         match_d = match_q & ~grant;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) match_q <= '0;
    else             match_q <= match_d;
  end

  assign hit_data = hit_any ? rows[hit_row] : '0;

  // R8
  wr_blocks_search_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && search_en && !pop) |=> $stable(match_q));

  // R5
  key_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (search_en && !wr_en && (key_in == '0)) |=> (match_q == $past(valid)));

  // R6
  invalid_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (search_en && !wr_en) |=> ((match_q & ~$past(valid)) == '0));

  // R11
  pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop && hit_any && !(search_en && !wr_en)) |=> !match_q[$past(hit_row)]);
endmodule

// File: tb/cam_search_unit_tb.sv
module cam_search_unit_tb;
  localparam int WORDS = 8;
  localparam int WIDTH = 9;
  localparam int ROW_W = 3;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, wr_live, search_en, pop;
  logic [ROW_W-1:0] wr_row;
  logic [WIDTH-1:0] wr_data, arg_in, key_in;
  logic             hit_any;
  logic [CNT_W-1:0] hit_count;
  logic [ROW_W-1:0] hit_row;
  logic [WIDTH-1:0] hit_data;

  always #10 clk = ~clk;

  cam_search_unit #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .wr_live(wr_live), .search_en(search_en),
    .arg_in(arg_in), .key_in(key_in), .pop(pop), .hit_any(hit_any),
    .hit_count(hit_count), .hit_row(hit_row), .hit_data(hit_data)
  );

  typedef struct {
    int               due;
    string            tag;
    logic             any;
    int               cnt;
    int               row;
    logic [WIDTH-1:0] data;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   failed = 0;
  bit   done = 0;

  // Bench model built from the requirements.
  logic [WIDTH-1:0] m_mem [WORDS];
  logic [WORDS-1:0] m_valid = '0;
  logic [WORDS-1:0] m_match = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lowest(input logic [WORDS-1:0] v);
    for (int i = 0; i < WORDS; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.due  = cyc + 1;
    e.tag  = tag;
    e.any  = (m_match != '0);
    e.cnt  = $countones(m_match);
    e.row  = lowest(m_match);
    e.data = e.any ? m_mem[e.row] : '0;
    q.push_back(e);
  endtask

  // Drive one cycle at the falling edge and queue its expected result.
  task automatic cycle(input string tag, input bit we, input int row,
                       input logic [WIDTH-1:0] data, input bit live,
                       input bit se, input logic [WIDTH-1:0] arg,
                       input logic [WIDTH-1:0] key, input bit pp);
    logic [WORDS-1:0] nm;
    wr_en = we; wr_row = ROW_W'(row); wr_data = data; wr_live = live;
    search_en = se; arg_in = arg; key_in = key; pop = pp;
    nm = m_match;
    if (se && !we) begin
      for (int i = 0; i < WORDS; i++)
        nm[i] = m_valid[i] && ((~(m_mem[i] ^ arg) | ~key) == '1);
    end else if (pp && m_match != '0) begin
      nm[lowest(m_match)] = 1'b0;
    end
    if (we) begin
      m_mem[row]   = data;
      m_valid[row] = live;
    end
    m_match = nm;
    push_exp(tag);
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input int row, input logic [WIDTH-1:0] d, input bit live);
    cycle(tag, 1, row, d, live, 0, '0, '0, 0);
  endtask
  task automatic srch(input string tag, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
    cycle(tag, 0, 0, '0, 0, 1, a, k, 0);
  endtask
  task automatic popc(input string tag);
    cycle(tag, 0, 0, '0, 0, 0, '0, '0, 1);
  endtask
  task automatic idle(input string tag);
    cycle(tag, 0, 0, '0, 0, 0, '0, '0, 0);
  endtask

  // Monitor: compares each item on the falling edge after it is due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (hit_any !== e.any || int'(hit_count) != e.cnt ||
          int'(hit_row) != e.row || hit_data !== e.data) begin
        failed++;
        $display("FAIL %s: got any=%0b cnt=%0d row=%0d data=%b, expected any=%0b cnt=%0d row=%0d data=%b",
                 e.tag, hit_any, hit_count, hit_row, hit_data, e.any, e.cnt, e.row, e.data);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_row = '0; wr_data = '0; wr_live = 0;
    search_en = 0; arg_in = '0; key_in = '0; pop = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    total++;
    if (hit_any !== 1'b0 || hit_count !== '0 || hit_row !== '0 || hit_data !== '0) begin
      failed++;
      $display("FAIL R1: got any=%0b cnt=%0d row=%0d data=%b, expected all zero",
               hit_any, hit_count, hit_row, hit_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle("R1 after release");
    srch("R1 rows invalid after reset", '0, '0);

    // R2: fill rows, row 4 written but not live
    wr("R2 write row0", 0, 9'b100111100, 1);
    wr("R2 write row1", 1, 9'b101000011, 1);
    wr("R2 write row2", 2, 9'b101111111, 1);
    wr("R2 write row3", 3, 9'b000000000, 1);
    wr("R2 write row4 not live", 4, 9'b101000011, 0);
    wr("R2 write row5", 5, 9'b101010101, 1);
    srch("R2 exact search row3", 9'b000000000, 9'h1FF);

    // R3, R6: top three bits compared
    srch("R3 R6 masked search", 9'b101111100, 9'b111000000);
    popc("R11 pop to next");
    popc("R11 pop to last");
    popc("R11 pop to empty");
    popc("R11 pop when empty");

    // R5: all-zero key
    srch("R5 zero key", 9'b010101010, '0);
    idle("R7 hold 1");
    idle("R7 hold 2");

    // R4: only the low two bits compared
    srch("R4 low bits key", 9'b010100011, 9'b000000011);
    srch("R3 no match", 9'b010000000, 9'h1FF);

    // R8: write and search together
    cycle("R8 write wins", 1, 6, 9'b010000000, 1, 1, 9'b010000000, 9'h1FF, 0);
    srch("R8 written row found", 9'b010000000, 9'h1FF);

    // R6: retire row1, then all-zero key
    wr("R6 invalidate row1", 1, 9'b101000011, 0);
    srch("R6 invalid row excluded", '0, '0);

    // R11: search beats pop in same cycle
    cycle("R11 search over pop", 0, 0, '0, 0, 1, 9'b101000000, 9'b111000000, 1);
    // R9: data follows a rewrite of the presented row
    wr("R9 rewrite presented row", 2, 9'b101000001, 1);
    // R11: pop together with a write
    cycle("R11 pop with write", 1, 7, 9'b111111111, 1, 1, '0, '0, 1);
    idle("R10 final");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule